// File: doc/BRIEF.md
# Timer Update-Event and Preload Controller

This block is the core of an up-counting general-purpose timer. A kernel-clock prescaler produces counting ticks, a 16-bit counter advances on each tick and wraps to zero after reaching the active auto-reload limit, and a set of shadow registers holds the active prescaler and auto-reload values. An update event copies the buffered values into these shadow registers. An update event has three possible sources: counter overflow, a software update strobe, or an external reset input.

A simple write port sets a control word, the buffered prescaler, the auto-reload value, the software strobe and the flag clear. Separate control bits decide how an update event behaves. One bit suppresses update events. One bit restricts the interrupt request to overflow only. One bit stops the counter after the next update. One bit makes auto-reload writes wait for an update instead of taking effect at once. The block outputs the counter readback, which can carry the update flag in bit 31. It also outputs a sticky update flag, a one-cycle request pulse, and a sampling-clock enable whose period is set by a division code.

Counting is controlled by a two-state machine. ST_HALT leaves the counter and prescaler frozen. ST_COUNT advances them. Three transitions link the states. GO moves from ST_HALT to ST_COUNT on a control write with bit 0 = 1. STOP moves from ST_COUNT to ST_HALT on a control write with bit 0 = 0. ONE_SHOT_END moves from ST_COUNT to ST_HALT on an update event while one-pulse mode is set.

Top module: `tmr_upd_core`

## Requirements
- R1: Control word (wr_sel = 0) bit 0 is the enable. When it is 0, the counter and prescaler hold their values. When it is 1, they advance on every kernel clock.
- R2: The prescaler counts kernel clocks from 0 up to the active prescaler value, then issues one counter tick. The buffered value (wr_sel = 1) becomes active only on an update event.
- R3: On a tick while it equals the active auto-reload value, the counter wraps to 0. This overflow is an update source.
- R4: When control bit 1 (update-off) is set, no update event, request or flag occurs, and the active prescaler and auto-reload values are kept. A software strobe (wr_sel = 3, bit 0 = 1) or an ext_rst pulse still zeroes the counter and prescaler.
- R5: When control bit 2 is 0, overflow, the software strobe and ext_rst all raise upd_req. When it is 1, only overflow does. upd_req is high for the one cycle after the edge that processes the event.
- R6: When control bit 3 (one-pulse) is set, an update event clears the enable. Counting then stops, with the counter at 0.
- R7: When control bit 4 is 0, an auto-reload write (wr_sel = 2) takes effect at once. When it is 1, the write is buffered and becomes active at the next update event.
- R8: upd_flag is set together with every upd_req. It stays set until a write with wr_sel = 4 and bit 0 = 0. A write with bit 0 = 1 leaves it unchanged.
- R9: When control bit 7 is set, cnt_rd[31] shows upd_flag. Otherwise cnt_rd[31] reads 0. Bits 30:16 always read 0.
- R10: Control bits 6:5 select the smp_en period. Codes 0, 1 and 2 give a period of 1, 2 and 4 kernel clocks. Code 3 behaves like code 0.
- R11: After reset, all control fields are 0, the counter, prescaler and flag are 0, and both auto-reload registers hold 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 3 | Target: 0 control, 1 prescaler, 2 auto-reload, 3 event, 4 flag |
| wr_data | input | 16 | Write data |
| ext_rst | input | 1 | External counter reset, acting as an update source |
| cnt_rd | output | 32 | Counter readback, with the optional flag in bit 31 |
| upd_flag | output | 1 | Sticky update flag |
| upd_req | output | 1 | One-cycle update request pulse |
| smp_en | output | 1 | Divided sampling-clock enable |

## Verification
Every result is registered. A write, strobe or ext_rst sampled at one clock edge shows its effect on cnt_rd, upd_flag and upd_req right after that edge, so it is visible at the following falling edge. smp_en follows the stored division code in the same cycle. A behavioural model in the bench takes the same inputs at every rising edge and predicts all four outputs. The bench compares those predictions with the design at each falling edge. Scenario checks then read results one falling edge after a write returns, or at the falling edge on which upd_req is first seen high.

// File: rtl/tmr_upd_pkg.sv
package tmr_upd_pkg;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    // control word bits 7:1, most significant first
    typedef struct packed {
        logic       mirror;
        logic [1:0] div;
        logic       arl_buf;
        logic       one_shot;
        logic       req_narrow;
        logic       upd_off;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
    localparam logic [SEL_W-1:0] SEL_PSC  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ARL  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_EVT  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;

endpackage

// File: rtl/tmr_upd_prescale.sv
module tmr_upd_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         reinit,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] div_q;

    assign tick = run && (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (reinit || tick) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_upd_counter.sv
module tmr_upd_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reinit,
    input  logic [W-1:0] top,
    output logic [W-1:0] value,
    output logic         wrap
);
    assign wrap = tick && (value == top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (reinit || wrap) begin
            value <= '0;
        end else if (tick) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_upd_clkdiv.sv
module tmr_upd_clkdiv #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] code,
    output logic             smp_en
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        unique case (code)
            2'd1:    mask = 2'b01;
            2'd2:    mask = 2'b11;
            default: mask = 2'b00;
        endcase
    end

    assign smp_en = (phase_q & mask) == '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/tmr_upd_core.sv
module tmr_upd_core
    import tmr_upd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RB_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_rst,
    output logic [RB_W-1:0]  cnt_rd,
    output logic             upd_flag,
    output logic             upd_req,
    output logic             smp_en
);
    localparam int PAD_W = RB_W - 1 - CNT_W;

    tmr_state_e       state_q, state_d;
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] psc_buf, psc_act, arl_buf, arl_act, cnt_val;
    logic             run, tick, wrap, reinit, uev, req_now;
    logic             wr_ctrl, wr_psc, wr_arl, wr_evt, wr_stat;

    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    assign wr_psc  = wr_en && (wr_sel == SEL_PSC);
    assign wr_arl  = wr_en && (wr_sel == SEL_ARL);
    assign wr_evt  = wr_en && (wr_sel == SEL_EVT);
    assign wr_stat = wr_en && (wr_sel == SEL_STAT);

    assign run     = (state_q == ST_COUNT);
    assign reinit  = (wr_evt && wr_data[0]) || ext_rst;
    assign uev     = (wrap || reinit) && !ctrl_q.upd_off;
    assign req_now = uev && (wrap || !ctrl_q.req_narrow);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions: GO, STOP, ONE_SHOT_END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (wr_ctrl && wr_data[0]) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (wr_ctrl)
                    state_d = wr_data[0] ? ST_COUNT : ST_HALT;
                else if (uev && ctrl_q.one_shot)
                    state_d = ST_HALT;
            end
        endcase
    end

    // registered outputs and shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            psc_buf  <= '0;
            psc_act  <= '0;
            arl_buf  <= '1;
            arl_act  <= '1;
            upd_flag <= 1'b0;
            upd_req  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W:1]);
            if (uev)     psc_act <= psc_buf;
            if (wr_psc)  psc_buf <= wr_data;
            if (wr_arl && !ctrl_q.arl_buf) arl_act <= wr_data;
            else if (uev)                  arl_act <= arl_buf;
            if (wr_arl)  arl_buf <= wr_data;
            if (req_now)                      upd_flag <= 1'b1;
            else if (wr_stat && !wr_data[0])  upd_flag <= 1'b0;
            upd_req <= req_now;
        end
    end

    tmr_upd_prescale #(.W(CNT_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reinit (reinit),
        .limit  (psc_act),
        .tick   (tick)
    );

    tmr_upd_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .reinit (reinit),
        .top    (arl_act),
        .value  (cnt_val),
        .wrap   (wrap)
    );

    tmr_upd_clkdiv #(.DIV_W(2)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (ctrl_q.div),
        .smp_en (smp_en)
    );

    assign cnt_rd = {upd_flag & ctrl_q.mirror, {PAD_W{1'b0}}, cnt_val};

endmodule

// File: rtl/tmr_upd_check.sv
module tmr_upd_check #(
    parameter int CNT_W = 16,
    parameter int RB_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             reinit,
    input logic             tick,
    input logic             wrap,
    input logic             uev,
    input logic             wr_ctrl,
    input logic             udis,
    input logic             one_shot,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] psc_act,
    input logic [RB_W-1:0]  cnt_rd,
    input logic             upd_flag,
    input logic             upd_req
);
    assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reinit) |=> $stable(cnt_val));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap && !reinit) |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !reinit) |=> (cnt_val == '0));

    assert_shadow_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        udis |=> $stable(psc_act));

    assert_one_pulse_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uev && one_shot && !wr_ctrl) |=> !run);

    assert_req_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |-> upd_flag);

    assert_mirror_tracks_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd[RB_W-1] |-> upd_flag);
endmodule

bind tmr_upd_core tmr_upd_check #(.CNT_W(CNT_W), .RB_W(RB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .reinit   (reinit),
    .tick     (tick),
    .wrap     (wrap),
    .uev      (uev),
    .wr_ctrl  (wr_ctrl),
    .udis     (ctrl_q.upd_off),
    .one_shot (ctrl_q.one_shot),
    .cnt_val  (cnt_val),
    .psc_act  (psc_act),
    .cnt_rd   (cnt_rd),
    .upd_flag (upd_flag),
    .upd_req  (upd_req)
);

// File: tb/sim_tmr_upd_core.sv
`timescale 1ns/1ps
module sim_tmr_upd_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        ext_rst = 1'b0;
    logic [31:0] cnt_rd;
    logic        upd_flag, upd_req, smp_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_upd_core u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_rst(ext_rst), .cnt_rd(cnt_rd),
        .upd_flag(upd_flag), .upd_req(upd_req), .smp_en(smp_en)
    );

    // behavioural reference model
    bit [15:0] m_cnt = 0, m_psc = 0, m_pa = 0, m_pb = 0;
    bit [15:0] m_aa = 16'hFFFF, m_ab = 16'hFFFF;
    bit        m_run = 0, m_udis = 0, m_urs = 0, m_opm = 0, m_arpe = 0, m_mir = 0;
    bit [1:0]  m_ckd = 0, m_div = 0;
    bit        m_flag = 0, m_req = 0;

    always @(posedge clk) begin
        bit re, tk, ov, ue, rq;
        bit [15:0] n_cnt, n_psc;
        if (!rst_n) begin
            m_cnt = 0; m_psc = 0; m_pa = 0; m_pb = 0; m_aa = 16'hFFFF; m_ab = 16'hFFFF;
            m_run = 0; m_udis = 0; m_urs = 0; m_opm = 0; m_arpe = 0; m_mir = 0;
            m_ckd = 0; m_div = 0; m_flag = 0; m_req = 0;
        end else begin
            re = (wr_en && wr_sel == 3 && wr_data[0]) || ext_rst;
            tk = m_run && (m_psc == m_pa);
            ov = tk && (m_cnt == m_aa);
            ue = (ov || re) && !m_udis;
            rq = ue && (ov || !m_urs);
            n_cnt = re ? 16'd0 : (tk ? (ov ? 16'd0 : m_cnt + 16'd1) : m_cnt);
            n_psc = re ? 16'd0 : (m_run ? ((m_psc == m_pa) ? 16'd0 : m_psc + 16'd1) : m_psc);
            if (ue) m_pa = m_pb;
            if (wr_en && wr_sel == 1) m_pb = wr_data;
            if (wr_en && wr_sel == 2 && !m_arpe) m_aa = wr_data;
            else if (ue) m_aa = m_ab;
            if (wr_en && wr_sel == 2) m_ab = wr_data;
            if (wr_en && wr_sel == 0) begin
                m_run = wr_data[0]; m_udis = wr_data[1]; m_urs = wr_data[2];
                m_opm = wr_data[3]; m_arpe = wr_data[4]; m_ckd = wr_data[6:5];
                m_mir = wr_data[7];
            end else if (ue && m_opm) begin
                m_run = 0;
            end
            if (rq) m_flag = 1;
            else if (wr_en && wr_sel == 4 && !wr_data[0]) m_flag = 0;
            m_req = rq;
            m_div = m_div + 2'd1;
            m_cnt = n_cnt;
            m_psc = n_psc;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit [1:0] code, mask;
        if (rst_n && !done) begin
            chk(cnt_rd == {m_mir & m_flag, 15'd0, m_cnt}, "R3 model cnt_rd", cnt_rd, {m_mir & m_flag, 15'd0, m_cnt});
            chk(upd_req == m_req, "R5 model upd_req", 32'(upd_req), 32'(m_req));
            chk(upd_flag == m_flag, "R8 model upd_flag", 32'(upd_flag), 32'(m_flag));
            code = (m_ckd == 2'd3) ? 2'd0 : m_ckd;
            mask = (code == 2'd0) ? 2'b00 : ((code == 2'd1) ? 2'b01 : 2'b11);
            chk(smp_en == ((m_div & mask) == 2'b00), "R10 model smp_en", 32'(smp_en), 32'((m_div & mask) == 2'b00));
        end
    end

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_req(output int maxv, output bit seen);
        maxv = 0; seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (upd_req) seen = 1;
            else if (int'(cnt_rd[15:0]) > maxv) maxv = int'(cnt_rd[15:0]);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int mx, hi;
        bit seen;
        logic [15:0] v;
        idle(2);
        chk(cnt_rd == 0, "R11 reset cnt_rd", cnt_rd, 0);
        chk(upd_flag == 0 && upd_req == 0, "R11 reset flag/req", {upd_flag, upd_req}, 0);
        rst_n = 1'b1;

        // R1 enable then hold
        wr(0, 16'h0001);
        idle(5);
        chk(cnt_rd[15:0] != 0, "R1 counting", cnt_rd, 32'd5);
        wr(0, 16'h0000);
        v = cnt_rd[15:0];
        idle(4);
        chk(cnt_rd[15:0] == v, "R1 hold", cnt_rd, 32'(v));

        // R2 prescaler of 3 clocks, loaded by strobe
        wr(1, 16'd2);
        wr(3, 16'd1);
        wr(0, 16'h0001);
        v = cnt_rd[15:0];
        idle(3);
        chk(cnt_rd[15:0] == v + 16'd1, "R2 one tick per three clocks", cnt_rd, 32'(v + 16'd1));

        // R3 immediate auto-reload and overflow
        wr(3, 16'd1);
        wr(2, 16'd4);
        wait_req(mx, seen);
        chk(seen && cnt_rd[15:0] == 0, "R3 wrap to zero", cnt_rd, 0);
        chk(mx == 4, "R3 top value reached", mx, 4);
        chk(upd_flag == 1, "R8 flag set", upd_flag, 1);

        // R8 flag clear rules
        wr(0, 16'h0000);
        wr(4, 16'd1);
        chk(upd_flag == 1, "R8 write one keeps flag", upd_flag, 1);
        wr(4, 16'd0);
        chk(upd_flag == 0, "R8 write zero clears", upd_flag, 0);

        // R5 request source
        wr(0, 16'h0004);
        wr(3, 16'd1);
        chk(upd_req == 0 && upd_flag == 0, "R5 narrow blocks strobe", {upd_req, upd_flag}, 0);
        wr(0, 16'h0000);
        wr(3, 16'd1);
        chk(upd_req == 1, "R5 strobe raises request", upd_req, 1);
        wr(4, 16'd0);

        // R4 update-off keeps shadows, reinit still works
        wr(0, 16'h0002);
        wr(1, 16'd0);
        @(negedge clk); ext_rst = 1'b1;
        @(negedge clk); ext_rst = 1'b0;
        chk(upd_req == 0, "R4 ext_rst no request", upd_req, 0);
        wr(0, 16'h0003);
        v = cnt_rd[15:0];
        idle(3);
        chk(cnt_rd[15:0] == ((v == 16'd4) ? 16'd0 : v + 16'd1), "R4 prescaler kept", cnt_rd, 32'(v + 16'd1));
        idle(4);
        wr(3, 16'd1);
        chk(cnt_rd[15:0] == 0 && upd_req == 0, "R4 strobe zeroes counter", cnt_rd, 0);

        // R7 buffered auto-reload
        wr(0, 16'h0011);
        wr(2, 16'd8);
        wait_req(mx, seen);
        chk(seen && mx == 4, "R7 old limit until update", mx, 4);
        wait_req(mx, seen);
        chk(seen && mx == 8, "R7 new limit after update", mx, 8);

        // R6 one-pulse
        wr(0, 16'h0009);
        wait_req(mx, seen);
        chk(seen, "R6 update reached", seen, 1);
        idle(5);
        chk(cnt_rd[15:0] == 0 && upd_req == 0, "R6 stopped at zero", cnt_rd, 0);

        // R9 flag mirror
        wr(0, 16'h0080);
        chk(cnt_rd[31] == 1, "R9 mirror shows flag", cnt_rd, 32'h80000000);
        wr(4, 16'd0);
        chk(cnt_rd[31] == 0, "R9 mirror follows clear", cnt_rd, 0);
        wr(0, 16'h0000);
        wr(3, 16'd1);
        chk(cnt_rd[31] == 0 && upd_flag == 1, "R9 no mirror when off", cnt_rd, 0);

        // R10 sampling enable period
        for (int c = 0; c < 4; c++) begin
            wr(0, 16'(c << 5));
            hi = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (smp_en) hi++;
            end
            chk(hi == ((c == 1) ? 4 : ((c == 2) ? 2 : 8)), "R10 pulses per eight clocks", hi,
                (c == 1) ? 4 : ((c == 2) ? 2 : 8));
        end

        finish_run();
    end
endmodule